// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes the processor into an exception handler. When the core raises a one-cycle entry request, it gives the class of the event, a cause code, a debug sub-cause, the PC of the faulting instruction and whether that instruction sits in a branch delay slot. On the next clock edge the block produces the handler address and updates the saved return addresses and the cause and debug fields. There are three entry kinds. A general exception saves into the exception return register. A cold reset, soft reset or NMI saves into the error return register. A debug event saves into the debug return register.

The status bits (exception level, error level, boot-vector select, debug mode, user mode) and the delay-slot flag belong to the surrounding core. The core presents their current values as inputs. The block registers them unchanged on a cycle without an entry, and registers the modified values on an entry cycle. The return registers, the cause fields, the debug cause bits and the soft-reset and NMI flags are held inside the block.

Top module: `exc_entry_seq`

## Requirements
- R1: A general entry (class 0) with `exc_lvl_i` low sets `ret_pc_o` to `pc_i - 4` and `cause_slot_o` to 1 when `slot_i` is high. Otherwise it sets `ret_pc_o` to `pc_i` and `cause_slot_o` to 0.
- R2: A general entry with `exc_lvl_i` high leaves `ret_pc_o` and `cause_slot_o` unchanged. Every general entry sets `exc_lvl_o` to 1.
- R3: A general entry jumps to 0xBFC00200 when `boot_vec_i` is high. Otherwise it jumps to `ebase_i` with bits 9:0 forced to zero.
- R4: A general entry writes `code_i` into `cause_code_o`. It writes `cop_num_i` into `cop_num_o` only when `code_i` is 11 (coprocessor unusable); any other code leaves `cop_num_o` unchanged.
- R5: A cold reset (class 1), a soft reset (class 2) or an NMI (class 3) saves the slot-adjusted PC (`pc_i - 4` when `slot_i` is high, otherwise `pc_i`) into `err_ret_pc_o`. It sets `err_lvl_o` and `boot_vec_o` and jumps to 0xBFC00000. A cold reset clears `soft_rst_o` and `nmi_flag_o`. A soft reset sets `soft_rst_o` and raises `watch_clr_o` for one cycle. An NMI sets `nmi_flag_o`.
- R6: A debug entry (class 4) saves the slot-adjusted PC into `dbg_ret_pc_o`, except that sub-cause 0 (single step) always saves `pc_i`. It sets bit `dsub_i` of `dbg_cause_o` (1 = debug interrupt, 2 = instruction break, 3 = break instruction, 4 = data store break, 5 = data load break); earlier bits stay set. It sets `dbg_mode_o` and jumps to 0xBFC00480.
- R7: Reset, NMI and debug entries clear `cause_slot_o` only when `exc_lvl_i` is low; otherwise `cause_slot_o` keeps its value.
- R8: After any entry, `user_o` and `slot_o` are 0.
- R9: A general entry with code 0 (external interrupt) raised while `dbg_mode_i` is high is taken as a debug entry with sub-cause 1. `cause_code_o` is not written.
- R10: A request carrying class 5, 6 or 7 is ignored. It behaves exactly like a cycle without a request.
- R11: On a cycle without an entry, `pc_o`, the three return registers, the cause fields and the debug bits hold their values. The status outputs `exc_lvl_o`, `err_lvl_o`, `boot_vec_o`, `dbg_mode_o`, `user_o` and `slot_o` take the values of the matching inputs, and `watch_clr_o` is 0.
- R12: While `rst_ni` is low, `pc_o` is 0xBFC00000 and `err_lvl_o` and `boot_vec_o` are 1. Every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle entry request |
| cls_i | input | 3 | Entry class: 0 general, 1 cold reset, 2 soft reset, 3 NMI, 4 debug |
| code_i | input | 5 | Cause code for a general entry |
| dsub_i | input | 3 | Debug sub-cause |
| cop_num_i | input | 2 | Coprocessor number for code 11 |
| pc_i | input | 32 | PC of the faulting instruction |
| slot_i | input | 1 | Faulting instruction is in a delay slot |
| exc_lvl_i | input | 1 | Current exception level |
| err_lvl_i | input | 1 | Current error level |
| boot_vec_i | input | 1 | Current boot-vector select |
| dbg_mode_i | input | 1 | Current debug mode |
| user_i | input | 1 | Current user mode |
| ebase_i | input | 32 | Exception base address |
| pc_o | output | 32 | Handler address |
| ret_pc_o | output | 32 | Exception return address |
| err_ret_pc_o | output | 32 | Error return address |
| dbg_ret_pc_o | output | 32 | Debug return address |
| cause_code_o | output | 5 | Stored cause code |
| cop_num_o | output | 2 | Stored coprocessor number |
| cause_slot_o | output | 1 | Stored delay-slot cause bit |
| dbg_cause_o | output | 6 | Sticky debug cause bits, indexed by sub-cause |
| exc_lvl_o | output | 1 | Updated exception level |
| err_lvl_o | output | 1 | Updated error level |
| boot_vec_o | output | 1 | Updated boot-vector select |
| dbg_mode_o | output | 1 | Updated debug mode |
| user_o | output | 1 | Updated user mode |
| soft_rst_o | output | 1 | Soft-reset status flag |
| nmi_flag_o | output | 1 | NMI status flag |
| slot_o | output | 1 | Updated delay-slot flag |
| watch_clr_o | output | 1 | One-cycle pulse that clears the watch register |

## Verification
Every entry class, including the three unused codes, is combined with each setting of the delay-slot flag, the exception level, the boot-vector select and debug mode. These combinations separate PC and PC-minus-4 capture, a frozen return register from a written one, and the boot vector from the base-derived vector. The cause codes 0, 11 and two others separate the interrupt-to-debug conversion and the coprocessor-number write from ordinary code writes. All six debug sub-causes are used, so single-step capture stands apart from slot-adjusted capture. Each entry is followed by an idle cycle with inverted status inputs, which shows that the stored registers hold while the status outputs follow the inputs.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EXC_GENERAL = 3'd0,
        EXC_COLD    = 3'd1,
        EXC_SOFT    = 3'd2,
        EXC_NMI     = 3'd3,
        EXC_DEBUG   = 3'd4
    } exc_class_e;

    typedef enum logic [2:0] {
        DSUB_STEP   = 3'd0,
        DSUB_INT    = 3'd1,
        DSUB_IBRK   = 3'd2,
        DSUB_SWBRK  = 3'd3,
        DSUB_DSTORE = 3'd4,
        DSUB_DLOAD  = 3'd5
    } dbg_sub_e;

    typedef enum logic [1:0] {
        VEC_GENERAL = 2'd0,
        VEC_ERROR   = 2'd1,
        VEC_DEBUG   = 2'd2
    } vec_kind_e;

    localparam logic [4:0] CODE_EXT_INT  = 5'd0;
    localparam logic [4:0] CODE_COP_UNUS = 5'd11;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int SUB_W  = 3
) (
    input  logic              req_i,
    input  logic [2:0]        cls_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [SUB_W-1:0]  dsub_i,
    input  logic              dbg_mode_i,
    output logic              take_gen_o,
    output logic              take_err_o,
    output logic              take_dbg_o,
    output logic              is_cold_o,
    output logic              is_soft_o,
    output logic              is_nmi_o,
    output logic [SUB_W-1:0]  eff_sub_o
);
    logic int_in_dbg;

    always_comb begin
        // an external interrupt seen in debug mode becomes a debug entry
        int_in_dbg = (cls_i == EXC_GENERAL) && (code_i == CODE_W'(CODE_EXT_INT)) && dbg_mode_i;
        take_gen_o = req_i && (cls_i == EXC_GENERAL) && !int_in_dbg;
        is_cold_o  = req_i && (cls_i == EXC_COLD);
        is_soft_o  = req_i && (cls_i == EXC_SOFT);
        is_nmi_o   = req_i && (cls_i == EXC_NMI);
        take_err_o = is_cold_o || is_soft_o || is_nmi_o;
        take_dbg_o = req_i && ((cls_i == EXC_DEBUG) || int_in_dbg);
        eff_sub_o  = int_in_dbg ? SUB_W'(DSUB_INT) : dsub_i;
    end
endmodule

// File: rtl/exc_return_pc.sv
module exc_return_pc #(
    parameter int XLEN       = 32,
    parameter int SLOT_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            slot_i,
    input  logic            exact_i,
    output logic [XLEN-1:0] ret_o
);
    localparam logic [XLEN-1:0] STEP_BACK = XLEN'(SLOT_BYTES);

    always_comb begin
        ret_o = (slot_i && !exact_i) ? (pc_i - STEP_BACK) : pc_i;
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_entry_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              EBASE_ALIGN = 10,
    parameter logic [XLEN-1:0] BOOT_VEC    = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] GEN_OFS     = 32'h0000_0200,
    parameter logic [XLEN-1:0] DBG_OFS     = 32'h0000_0480
) (
    input  vec_kind_e       kind_i,
    input  logic            boot_vec_i,
    input  logic [XLEN-1:0] ebase_i,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] base_aligned;

    generate
        if (EBASE_ALIGN == 0) begin : g_no_align
            assign base_aligned = ebase_i;
        end else begin : g_align
            assign base_aligned = {ebase_i[XLEN-1:EBASE_ALIGN], {EBASE_ALIGN{1'b0}}};
        end
    endgenerate

    always_comb begin
        unique case (kind_i)
            VEC_GENERAL: vec_o = boot_vec_i ? (BOOT_VEC + GEN_OFS) : base_aligned;
            VEC_DEBUG:   vec_o = BOOT_VEC + DBG_OFS;
            default:     vec_o = BOOT_VEC;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              CODE_W      = 5,
    parameter int              COP_W       = 2,
    parameter int              DBG_W       = 6,
    parameter int              SLOT_BYTES  = 4,
    parameter int              EBASE_ALIGN = 10,
    parameter logic [XLEN-1:0] BOOT_VEC    = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] GEN_OFS     = 32'h0000_0200,
    parameter logic [XLEN-1:0] DBG_OFS     = 32'h0000_0480
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [2:0]        cls_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [2:0]        dsub_i,
    input  logic [COP_W-1:0]  cop_num_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              slot_i,
    input  logic              exc_lvl_i,
    input  logic              err_lvl_i,
    input  logic              boot_vec_i,
    input  logic              dbg_mode_i,
    input  logic              user_i,
    input  logic [XLEN-1:0]   ebase_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   ret_pc_o,
    output logic [XLEN-1:0]   err_ret_pc_o,
    output logic [XLEN-1:0]   dbg_ret_pc_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic [COP_W-1:0]  cop_num_o,
    output logic              cause_slot_o,
    output logic [DBG_W-1:0]  dbg_cause_o,
    output logic              exc_lvl_o,
    output logic              err_lvl_o,
    output logic              boot_vec_o,
    output logic              dbg_mode_o,
    output logic              user_o,
    output logic              soft_rst_o,
    output logic              nmi_flag_o,
    output logic              slot_o,
    output logic              watch_clr_o
);
    localparam int SUB_W = 3;

    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ret_pc;
        logic [XLEN-1:0]   err_pc;
        logic [XLEN-1:0]   dbg_pc;
        logic [CODE_W-1:0] code;
        logic [COP_W-1:0]  cop;
        logic              bd;
        logic [DBG_W-1:0]  dbg;
        logic              exl;
        logic              erl;
        logic              bev;
        logic              dm;
        logic              um;
        logic              sr;
        logic              nmi;
        logic              slot;
        logic              wclr;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        pc: BOOT_VEC, ret_pc: '0, err_pc: '0, dbg_pc: '0, code: '0, cop: '0,
        bd: 1'b0, dbg: '0, exl: 1'b0, erl: 1'b1, bev: 1'b1, dm: 1'b0,
        um: 1'b0, sr: 1'b0, nmi: 1'b0, slot: 1'b0, wclr: 1'b0
    };

    seq_state_t st_d, st_q;

    logic             take_gen, take_err, take_dbg;
    logic             is_cold, is_soft, is_nmi;
    logic [SUB_W-1:0] eff_sub;
    logic             exact_pc;
    logic [XLEN-1:0]  adj_pc;
    vec_kind_e        vkind;
    logic [XLEN-1:0]  vec;

    exc_classify #(.CODE_W(CODE_W), .SUB_W(SUB_W)) u_classify (
        .req_i      (req_i),
        .cls_i      (cls_i),
        .code_i     (code_i),
        .dsub_i     (dsub_i),
        .dbg_mode_i (dbg_mode_i),
        .take_gen_o (take_gen),
        .take_err_o (take_err),
        .take_dbg_o (take_dbg),
        .is_cold_o  (is_cold),
        .is_soft_o  (is_soft),
        .is_nmi_o   (is_nmi),
        .eff_sub_o  (eff_sub)
    );

    assign exact_pc = take_dbg && (eff_sub == SUB_W'(DSUB_STEP));

    exc_return_pc #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_ret (
        .pc_i    (pc_i),
        .slot_i  (slot_i),
        .exact_i (exact_pc),
        .ret_o   (adj_pc)
    );

    always_comb begin
        if (take_dbg)      vkind = VEC_DEBUG;
        else if (take_err) vkind = VEC_ERROR;
        else               vkind = VEC_GENERAL;
    end

    exc_vector #(
        .XLEN(XLEN), .EBASE_ALIGN(EBASE_ALIGN),
        .BOOT_VEC(BOOT_VEC), .GEN_OFS(GEN_OFS), .DBG_OFS(DBG_OFS)
    ) u_vec (
        .kind_i     (vkind),
        .boot_vec_i (boot_vec_i),
        .ebase_i    (ebase_i),
        .vec_o      (vec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wclr = 1'b0;
        // status bits pass through unless an entry modifies them
        st_d.exl  = exc_lvl_i;
        st_d.erl  = err_lvl_i;
        st_d.bev  = boot_vec_i;
        st_d.dm   = dbg_mode_i;
        st_d.um   = user_i;
        st_d.slot = slot_i;

        if (take_gen) begin
            if (!exc_lvl_i) begin
                st_d.ret_pc = adj_pc;
                st_d.bd     = slot_i;
            end
            st_d.code = code_i;
            if (code_i == CODE_W'(CODE_COP_UNUS)) begin
                st_d.cop = cop_num_i;
            end
            st_d.exl  = 1'b1;
            st_d.um   = 1'b0;
            st_d.slot = 1'b0;
            st_d.pc   = vec;
        end else if (take_err) begin
            st_d.err_pc = adj_pc;
            if (!exc_lvl_i) begin
                st_d.bd = 1'b0;
            end
            st_d.erl  = 1'b1;
            st_d.bev  = 1'b1;
            st_d.um   = 1'b0;
            st_d.slot = 1'b0;
            st_d.pc   = vec;
            if (is_cold) begin
                st_d.sr  = 1'b0;
                st_d.nmi = 1'b0;
            end
            if (is_soft) begin
                st_d.sr   = 1'b1;
                st_d.wclr = 1'b1;
            end
            if (is_nmi) begin
                st_d.nmi = 1'b1;
            end
        end else if (take_dbg) begin
            st_d.dbg_pc = adj_pc;
            for (int i = 0; i < DBG_W; i++) begin
                if (eff_sub == SUB_W'(i)) begin
                    st_d.dbg[i] = 1'b1;
                end
            end
            if (!exc_lvl_i) begin
                st_d.bd = 1'b0;
            end
            st_d.dm   = 1'b1;
            st_d.um   = 1'b0;
            st_d.slot = 1'b0;
            st_d.pc   = vec;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o         = st_q.pc;
    assign ret_pc_o     = st_q.ret_pc;
    assign err_ret_pc_o = st_q.err_pc;
    assign dbg_ret_pc_o = st_q.dbg_pc;
    assign cause_code_o = st_q.code;
    assign cop_num_o    = st_q.cop;
    assign cause_slot_o = st_q.bd;
    assign dbg_cause_o  = st_q.dbg;
    assign exc_lvl_o    = st_q.exl;
    assign err_lvl_o    = st_q.erl;
    assign boot_vec_o   = st_q.bev;
    assign dbg_mode_o   = st_q.dm;
    assign user_o       = st_q.um;
    assign soft_rst_o   = st_q.sr;
    assign nmi_flag_o   = st_q.nmi;
    assign slot_o       = st_q.slot;
    assign watch_clr_o  = st_q.wclr;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 5,
    parameter logic [XLEN-1:0] BOOT_VEC = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] DBG_OFS  = 32'h0000_0480
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic [2:0]        cls_i,
    input logic [CODE_W-1:0] code_i,
    input logic              exc_lvl_i,
    input logic              dbg_mode_i,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   ret_pc_o,
    input logic [XLEN-1:0]   err_ret_pc_o,
    input logic [XLEN-1:0]   dbg_ret_pc_o,
    input logic [CODE_W-1:0] cause_code_o,
    input logic              cause_slot_o,
    input logic              exc_lvl_o,
    input logic              err_lvl_o,
    input logic              boot_vec_o,
    input logic              dbg_mode_o,
    input logic              user_o,
    input logic              slot_o
);
    logic gen_req, int_dbg_req, err_req, dbg_req, quiet;

    always_comb begin
        int_dbg_req = req_i && (cls_i == 3'd0) && (code_i == '0) && dbg_mode_i;
        gen_req     = req_i && (cls_i == 3'd0) && !int_dbg_req;
        err_req     = req_i && (cls_i >= 3'd1) && (cls_i <= 3'd3);
        dbg_req     = req_i && (cls_i == 3'd4);
        quiet       = !req_i || (cls_i > 3'd4);
    end

    // R2, R8: general entry raises the exception level and leaves user mode
    a_r2_general_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_req |=> exc_lvl_o && !user_o && !slot_o);

    // R2: return register and slot bit frozen when the level was already set
    a_r2_frozen_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_req && exc_lvl_i |=> $stable(ret_pc_o) && $stable(cause_slot_o));

    // R5: reset and NMI entries
    a_r5_error_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_req |=> err_lvl_o && boot_vec_o && (pc_o == BOOT_VEC));

    // R6: debug entry
    a_r6_debug_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_req |=> dbg_mode_o && (pc_o == BOOT_VEC + DBG_OFS));

    // R9: interrupt in debug mode becomes a debug entry, code untouched
    a_r9_int_in_debug: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_dbg_req |=> dbg_mode_o && $stable(cause_code_o) && (pc_o == BOOT_VEC + DBG_OFS));

    // R10, R11: no entry leaves the saved state alone
    a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        quiet |=> $stable(pc_o) && $stable(ret_pc_o) && $stable(err_ret_pc_o)
                  && $stable(dbg_ret_pc_o) && $stable(cause_code_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .BOOT_VEC(BOOT_VEC), .DBG_OFS(DBG_OFS)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .cls_i        (cls_i),
    .code_i       (code_i),
    .exc_lvl_i    (exc_lvl_i),
    .dbg_mode_i   (dbg_mode_i),
    .pc_o         (pc_o),
    .ret_pc_o     (ret_pc_o),
    .err_ret_pc_o (err_ret_pc_o),
    .dbg_ret_pc_o (dbg_ret_pc_o),
    .cause_code_o (cause_code_o),
    .cause_slot_o (cause_slot_o),
    .exc_lvl_o    (exc_lvl_o),
    .err_lvl_o    (err_lvl_o),
    .boot_vec_o   (boot_vec_o),
    .dbg_mode_o   (dbg_mode_o),
    .user_o       (user_o),
    .slot_o       (slot_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
    localparam logic [31:0] BOOT = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  cls_i = '0;
    logic [4:0]  code_i = '0;
    logic [2:0]  dsub_i = '0;
    logic [1:0]  cop_num_i = '0;
    logic [31:0] pc_i = '0;
    logic        slot_i = 1'b0, exc_lvl_i = 1'b0, err_lvl_i = 1'b0;
    logic        boot_vec_i = 1'b0, dbg_mode_i = 1'b0, user_i = 1'b0;
    logic [31:0] ebase_i = '0;

    logic [31:0] pc_o, ret_pc_o, err_ret_pc_o, dbg_ret_pc_o;
    logic [4:0]  cause_code_o;
    logic [1:0]  cop_num_o;
    logic        cause_slot_o;
    logic [5:0]  dbg_cause_o;
    logic        exc_lvl_o, err_lvl_o, boot_vec_o, dbg_mode_o, user_o;
    logic        soft_rst_o, nmi_flag_o, slot_o, watch_clr_o;

    always #2.5 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .cls_i(cls_i), .code_i(code_i),
        .dsub_i(dsub_i), .cop_num_i(cop_num_i), .pc_i(pc_i), .slot_i(slot_i),
        .exc_lvl_i(exc_lvl_i), .err_lvl_i(err_lvl_i), .boot_vec_i(boot_vec_i),
        .dbg_mode_i(dbg_mode_i), .user_i(user_i), .ebase_i(ebase_i),
        .pc_o(pc_o), .ret_pc_o(ret_pc_o), .err_ret_pc_o(err_ret_pc_o),
        .dbg_ret_pc_o(dbg_ret_pc_o), .cause_code_o(cause_code_o), .cop_num_o(cop_num_o),
        .cause_slot_o(cause_slot_o), .dbg_cause_o(dbg_cause_o), .exc_lvl_o(exc_lvl_o),
        .err_lvl_o(err_lvl_o), .boot_vec_o(boot_vec_o), .dbg_mode_o(dbg_mode_o),
        .user_o(user_o), .soft_rst_o(soft_rst_o), .nmi_flag_o(nmi_flag_o),
        .slot_o(slot_o), .watch_clr_o(watch_clr_o)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model of stored state
    logic [31:0] m_pc = BOOT, m_ret = '0, m_err = '0, m_dbgpc = '0;
    logic [4:0]  m_code = '0;
    logic [1:0]  m_cop = '0;
    logic        m_bd = 1'b0, m_sr = 1'b0, m_nmi = 1'b0;
    logic [5:0]  m_dbg = '0;
    logic [5:0]  m_stat;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 pc", pc_o, BOOT);
        chk("R12 status", {26'd0, exc_lvl_o, err_lvl_o, boot_vec_o, dbg_mode_o, user_o, slot_o},
            32'b0_1_1_0_0_0);
        chk("R12 saved", ret_pc_o | err_ret_pc_o | dbg_ret_pc_o, 32'd0);
        chk("R12 cause", {14'd0, cause_code_o, cop_num_o, cause_slot_o, dbg_cause_o,
                          soft_rst_o, nmi_flag_o, watch_clr_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk);

        for (int it = 0; it < 1024; it++) begin
            logic [2:0] c;
            logic s, x, b, d, e, sg, se, sd;
            logic [1:0] k;
            logic [4:0] cd;
            logic [2:0] sb, esub;
            logic [31:0] adj, vec;
            c  = it[9:7];
            s  = it[6]; x = it[5]; b = it[4]; d = it[3];
            k  = it[1:0];
            e  = it[2];
            cd = (k == 2'd0) ? 5'd0 : (k == 2'd1) ? 5'd11 : (k == 2'd2) ? 5'd7 : 5'd31;
            sb = 3'((32'(k) + 2 * 32'(b) + 32'(c)) % 6);

            req_i = 1'b1; cls_i = c; code_i = cd; dsub_i = sb; cop_num_i = k ^ {e, e};
            pc_i = 32'h0040_0000 + 32'(it) * 8; slot_i = s; exc_lvl_i = x;
            err_lvl_i = e; boot_vec_i = b; dbg_mode_i = d; user_i = 1'b1;
            ebase_i = 32'h8000_0000 | (32'(it) * 32'h0001_2345);

            sd   = (c == 3'd4) || (c == 3'd0 && cd == 5'd0 && d);
            sg   = (c == 3'd0) && !sd;
            se   = (c >= 3'd1) && (c <= 3'd3);
            esub = (c == 3'd4) ? sb : 3'd1;
            adj  = s ? pc_i - 32'd4 : pc_i;
            vec  = b ? 32'hBFC0_0200 : {ebase_i[31:10], 10'd0};
            m_stat = {x, e, b, d, 1'b1, s};

            if (sg) begin
                if (!x) begin m_ret = adj; m_bd = s; end
                m_code = cd;
                if (cd == 5'd11) m_cop = cop_num_i;
                m_stat = {1'b1, e, b, d, 2'b00};
                m_pc = vec;
            end else if (se) begin
                m_err = adj;
                if (!x) m_bd = 1'b0;
                m_stat = {x, 1'b1, 1'b1, d, 2'b00};
                m_pc = BOOT;
                if (c == 3'd1) begin m_sr = 1'b0; m_nmi = 1'b0; end
                if (c == 3'd2) m_sr = 1'b1;
                if (c == 3'd3) m_nmi = 1'b1;
            end else if (sd) begin
                m_dbgpc = (esub == 3'd0) ? pc_i : adj;
                m_dbg[esub] = 1'b1;
                if (!x) m_bd = 1'b0;
                m_stat = {x, e, b, 1'b1, 2'b00};
                m_pc = BOOT + 32'h480;
            end

            @(negedge clk);
            req_i = 1'b0;
            chk(sg ? "R3 vector" : se ? "R5 vector" : sd ? "R6 vector" : "R10 vector", pc_o, m_pc);
            chk("R1 R2 ret_pc", ret_pc_o, m_ret);
            chk("R1 R7 cause_slot", {31'd0, cause_slot_o}, {31'd0, m_bd});
            chk("R5 err_ret_pc", err_ret_pc_o, m_err);
            chk("R6 dbg_ret_pc", dbg_ret_pc_o, m_dbgpc);
            chk("R4 R9 cause_code", {27'd0, cause_code_o}, {27'd0, m_code});
            chk("R4 cop_num", {30'd0, cop_num_o}, {30'd0, m_cop});
            chk("R6 R9 dbg_cause", {26'd0, dbg_cause_o}, {26'd0, m_dbg});
            chk("R2 R8 status", {26'd0, exc_lvl_o, err_lvl_o, boot_vec_o, dbg_mode_o, user_o, slot_o},
                {26'd0, m_stat});
            chk("R5 flags", {29'd0, soft_rst_o, nmi_flag_o, watch_clr_o},
                {29'd0, m_sr, m_nmi, (c == 3'd2)});

            // idle cycle with inverted status inputs
            cls_i = ~c; slot_i = ~s; exc_lvl_i = ~x; err_lvl_i = ~e; boot_vec_i = ~b;
            dbg_mode_i = ~d; user_i = 1'b0; pc_i = ~pc_i;
            @(negedge clk);
            chk("R11 pc hold", pc_o, m_pc);
            chk("R11 saved hold", ret_pc_o ^ err_ret_pc_o ^ dbg_ret_pc_o, m_ret ^ m_err ^ m_dbgpc);
            chk("R11 status follow",
                {25'd0, exc_lvl_o, err_lvl_o, boot_vec_o, dbg_mode_o, user_o, slot_o, watch_clr_o},
                {25'd0, ~x, ~e, ~b, ~d, 1'b0, ~s, 1'b0});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule